// File: doc/BRIEF.md
# Chunked Spare-Area Address Mapper

This block turns a linear byte column into a stream of internal buffer addresses for a flash page controller. A flash page has a main area and a spare area. The main buffer is addressed directly from address 0. The spare bytes are not stored contiguously. The spare area is cut into one chunk per 512-byte sector, and each chunk sits in its own 64-byte slot starting at 0x1000. A host asks for a transfer by giving a configuration code, a starting column, a byte count and a direction. The block then issues one buffer address per clock until the count is used up. A write beat stores a byte in the spare store. A read beat returns a byte from it.

Each slot holds the spare size divided by the chunk count, rounded down to an even number. Offsets beyond the last regular slot are all kept in slot 7, so that slot absorbs the remainder. A request that starts in the main area continues into the spare area at spare offset 0 once it passes the end of the page. A request that would run past the end of the spare area is refused with an error.

Top module: `spare_addr_mapper`

## Requirements
- R1: After reset, req_ready is 1 and beat_valid, done, err and rd_valid are 0.
- R2: Configuration code 0 selects page 512 / spare 16, code 1 selects 2048 / 64, code 2 selects 4096 / 128 and code 3 selects 4096 / 218. The slot size is spare / (page / 512) with bit 0 cleared, giving 16, 16, 16 and 26 bytes.
- R3: A column c below the page size produces beat address c.
- R4: A spare offset o (column minus page size) produces address 0x1000 + s*0x40 + (o - s*slot_size), where s = min(o / slot_size, 7).
- R5: A transfer that crosses the end of the main area continues at spare offset 0, which is address 0x1000.
- R6: Inside a transfer, the last byte of a slot is followed directly by offset 0 of the next slot.
- R7: A request is accepted on a rising edge while req_ready is 1. Beat k appears after the (k+1)-th following edge, one beat per cycle. done is high together with the last beat.
- R8: If column + length exceeds page + spare, the block raises err and done one cycle after acceptance and issues no beat. A request that ends exactly at page + spare is accepted.
- R9: A request of length 0 raises done one cycle after acceptance, with no beat and no err.
- R10: req_ready is 0 while a transfer is in progress. A req_valid pulse during that time changes neither the beats nor their count.
- R11: A write beat (req_wr = 1) to the spare area stores the byte on wr_byte. Byte k must be on wr_byte during the cycle before beat k appears. A read beat to the spare area returns the stored byte on rd_data, with rd_valid high, one cycle after the beat. Main-area beats produce no rd_valid.
- R12: With code 3, spare offsets 182 through 217 all map into slot 7, at addresses 0x11C0 through 0x11E3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_cfg | input | 2 | Page/spare configuration code |
| req_col | input | 13 | Starting linear column |
| req_len | input | 13 | Byte count |
| req_wr | input | 1 | 1 = write, 0 = read |
| wr_byte | input | 8 | Write data for the next beat |
| req_ready | output | 1 | Block idle, request can be taken |
| beat_valid | output | 1 | A buffer address is issued this cycle |
| beat_addr | output | 13 | Buffer address of this beat |
| beat_wr | output | 1 | Direction of this beat |
| beat_spare | output | 1 | Beat lies in the spare region |
| done | output | 1 | Request finished |
| err | output | 1 | Request refused: runs past the spare end |
| rd_valid | output | 1 | rd_data holds a spare byte read |
| rd_data | output | 8 | Byte read from the spare store |

## Verification
Call the acceptance edge E0. Beat k is due after edge E0+k+1, so done falls on edge E0+len. For an error or a zero-length request, done falls on edge E0+1. Read data is due one edge after its beat. The bench counts falling edges from acceptance and compares the cycle in which it first sees done with that count. It captures beats and read bytes only at falling edges. It also keeps sampling for two cycles after done, so that a stray extra beat or a late read byte is caught.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int COL_W       = 13;
  localparam int LEN_W       = 13;
  localparam int ADDR_W      = 13;
  localparam int SECTOR      = 512;
  localparam int SLOT_N      = 8;
  localparam int SLOT_STRIDE = 64;
  localparam int SPARE_BASE  = 4096;
  localparam int SB_W        = 7;
  localparam int SPARE_W     = 8;
  localparam int IDX_W       = $clog2(SLOT_N);
  localparam int OFF_W       = $clog2(SLOT_STRIDE);

  typedef struct packed {
    logic [COL_W-1:0]   page;
    logic [SPARE_W-1:0] spare;
    logic [SB_W-1:0]    slot;
  } geom_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_st_e;

  function automatic geom_t mk_geom(input int code);
    int pg, sp, chunks, sb;
    geom_t g;
    case (code)
      0:       begin pg = 512;  sp = 16;  end
      1:       begin pg = 2048; sp = 64;  end
      2:       begin pg = 4096; sp = 128; end
      default: begin pg = 4096; sp = 218; end
    endcase
    chunks  = pg / SECTOR;
    sb      = (sp / chunks) & ~1;
    g.page  = COL_W'(pg);
    g.spare = SPARE_W'(sp);
    g.slot  = SB_W'(sb);
    return g;
  endfunction
endpackage

// File: rtl/spa_geom.sv
module spa_geom
  import spa_pkg::*;
#(
  parameter int CFG_N = 4,
  localparam int CFG_W = $clog2(CFG_N)
) (
  input  logic [CFG_W-1:0] cfg,
  output geom_t            geom
);
  geom_t tbl [CFG_N];

  for (genvar i = 0; i < CFG_N; i++) begin : g_tbl
    assign tbl[i] = mk_geom(i);
  end

  assign geom = tbl[cfg];
endmodule

// File: rtl/spa_slot_locate.sv
module spa_slot_locate
  import spa_pkg::*;
#(
  parameter int OW = COL_W,
  parameter int NS = SLOT_N,
  parameter int SW = SB_W,
  localparam int IW = $clog2(NS),
  parameter int FW = OFF_W
) (
  input  logic [OW-1:0] ofs,
  input  logic [SW-1:0] slot_bytes,
  output logic [IW-1:0] idx,
  output logic [FW-1:0] off
);
  logic [OW-1:0] sb_w;
  logic [NS-1:1] ge;
  logic [OW-1:0] base;

  assign sb_w = OW'(slot_bytes);

  // one comparator per slot boundary; the count of passed boundaries is
  // the slot index, which saturates at NS-1 by construction
  for (genvar k = 1; k < NS; k++) begin : g_bnd
    assign ge[k] = ofs >= (sb_w * OW'(k));
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k < NS; k++) idx = idx + IW'(ge[k]);
  end

  assign base = OW'(idx) * sb_w;
  assign off  = FW'(ofs - base);
endmodule

// File: rtl/spa_seq.sv
module spa_seq
  import spa_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int LW = LEN_W,
  parameter int AW = ADDR_W,
  parameter int NS = SLOT_N,
  parameter int ST = SLOT_STRIDE,
  parameter int BASE = SPARE_BASE,
  localparam int IW = $clog2(NS),
  localparam int FW = $clog2(ST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [CW-1:0] req_col,
  input  logic [LW-1:0] req_len,
  input  logic          req_wr,
  input  logic [7:0]    wr_byte,
  input  geom_t         geom,
  input  logic [IW-1:0] loc_idx,
  input  logic [FW-1:0] loc_off,
  output logic          req_ready,
  output logic          beat_valid,
  output logic [AW-1:0] beat_addr,
  output logic          beat_wr,
  output logic          beat_spare,
  output logic [7:0]    beat_wdata,
  output logic          done,
  output logic          err
);
  localparam int EW = (CW > LW ? CW : LW) + 1;

  seq_st_e       st;
  logic          in_spare;
  logic [CW-1:0] cur_col;
  logic [IW-1:0] cur_idx;
  logic [FW-1:0] cur_off;
  logic [LW-1:0] rem;
  logic          wr_q;
  logic          err_q;
  logic [CW-1:0] page_q;
  logic [SB_W-1:0] sb_q;

  logic [EW-1:0] end_pos, limit;
  logic          overflow, start_spare;
  logic [AW-1:0] map_addr;
  logic          slot_last;

  assign end_pos     = EW'(req_col) + EW'(req_len);
  assign limit       = EW'(geom.page) + EW'(geom.spare);
  assign overflow    = end_pos > limit;
  assign start_spare = req_col >= geom.page;
  assign req_ready   = (st == S_IDLE);

  assign map_addr  = in_spare ? AW'(BASE) + AW'(cur_idx) * AW'(ST) + AW'(cur_off)
                              : AW'(cur_col);
  assign slot_last = (cur_off == FW'(sb_q - SB_W'(1))) && (cur_idx != IW'(NS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      in_spare   <= 1'b0;
      cur_col    <= '0;
      cur_idx    <= '0;
      cur_off    <= '0;
      rem        <= '0;
      wr_q       <= 1'b0;
      err_q      <= 1'b0;
      page_q     <= '0;
      sb_q       <= '0;
      beat_valid <= 1'b0;
      beat_addr  <= '0;
      beat_wr    <= 1'b0;
      beat_spare <= 1'b0;
      beat_wdata <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      beat_valid <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            page_q   <= geom.page;
            sb_q     <= geom.slot;
            wr_q     <= req_wr;
            rem      <= req_len;
            cur_col  <= req_col;
            in_spare <= start_spare;
            cur_idx  <= start_spare ? loc_idx : '0;
            cur_off  <= start_spare ? loc_off : '0;
            err_q    <= overflow;
            st       <= (overflow || req_len == '0) ? S_FIN : S_RUN;
          end
        end
        S_RUN: begin
          beat_valid <= 1'b1;
          beat_addr  <= map_addr;
          beat_wr    <= wr_q;
          beat_spare <= in_spare;
          beat_wdata <= wr_byte;
          done       <= (rem == LW'(1));
          rem        <= rem - LW'(1);
          if (!in_spare) begin
            if (cur_col == page_q - CW'(1)) begin
              in_spare <= 1'b1;
              cur_idx  <= '0;
              cur_off  <= '0;
            end else begin
              cur_col <= cur_col + CW'(1);
            end
          end else if (slot_last) begin
            cur_idx <= cur_idx + IW'(1);
            cur_off <= '0;
          end else begin
            cur_off <= cur_off + FW'(1);
          end
          if (rem == LW'(1)) st <= S_IDLE;
        end
        S_FIN: begin
          done <= 1'b1;
          err  <= err_q;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spa_spare_ram.sv
module spa_spare_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spare_addr_mapper.sv
module spare_addr_mapper
  import spa_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int LW = LEN_W,
  parameter int AW = ADDR_W,
  localparam int RAM_D  = SLOT_N * SLOT_STRIDE,
  localparam int RAM_AW = $clog2(RAM_D)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_cfg,
  input  logic [CW-1:0] req_col,
  input  logic [LW-1:0] req_len,
  input  logic          req_wr,
  input  logic [7:0]    wr_byte,
  output logic          req_ready,
  output logic          beat_valid,
  output logic [AW-1:0] beat_addr,
  output logic          beat_wr,
  output logic          beat_spare,
  output logic          done,
  output logic          err,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);
  geom_t          geom;
  logic [CW-1:0]  spare_ofs;
  logic [IDX_W-1:0] loc_idx;
  logic [OFF_W-1:0] loc_off;
  logic [7:0]     beat_wdata;
  logic           ram_we, ram_re;

  spa_geom #(.CFG_N(4)) u_geom (.cfg(req_cfg), .geom(geom));

  assign spare_ofs = req_col - geom.page;

  spa_slot_locate #(.OW(CW), .NS(SLOT_N), .SW(SB_W), .FW(OFF_W)) u_loc (
    .ofs(spare_ofs), .slot_bytes(geom.slot), .idx(loc_idx), .off(loc_off)
  );

  spa_seq #(.CW(CW), .LW(LW), .AW(AW), .NS(SLOT_N), .ST(SLOT_STRIDE),
            .BASE(SPARE_BASE)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_col(req_col),
    .req_len(req_len), .req_wr(req_wr), .wr_byte(wr_byte), .geom(geom),
    .loc_idx(loc_idx), .loc_off(loc_off), .req_ready(req_ready),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_wr(beat_wr),
    .beat_spare(beat_spare), .beat_wdata(beat_wdata), .done(done), .err(err)
  );

  assign ram_we = beat_valid && beat_spare && beat_wr;
  assign ram_re = beat_valid && beat_spare && !beat_wr;

  spa_spare_ram #(.DEPTH(RAM_D), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(RAM_AW'(beat_addr - AW'(SPARE_BASE))),
    .wdata(beat_wdata), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= ram_re;
  end
endmodule

// File: rtl/spa_checker.sv
module spa_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        beat_valid,
  input logic [12:0] beat_addr,
  input logic        beat_wr,
  input logic        beat_spare,
  input logic        done,
  input logic        err,
  input logic        rd_valid
);
  AST_SPARE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_spare |-> beat_addr >= 13'h1000 && beat_addr < 13'h1200); // R4
  AST_MAIN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_spare |-> beat_addr < 13'h1000); // R3
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    beat_valid && $past(beat_valid) && beat_spare && $past(beat_spare) && beat_addr[5:0] != 6'd0
      |-> beat_addr == $past(beat_addr) + 13'd1); // R6
  AST_STREAM: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !done |=> beat_valid); // R7
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
    err |-> done && !beat_valid); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !done |-> !req_ready); // R10
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(beat_valid && beat_spare && !beat_wr)); // R11
endmodule

bind spare_addr_mapper spa_checker u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .beat_valid(beat_valid),
  .beat_addr(beat_addr), .beat_wr(beat_wr), .beat_spare(beat_spare),
  .done(done), .err(err), .rd_valid(rd_valid)
);

// File: tb/sim_spare_addr_mapper.sv
`timescale 1ns/1ps
module sim_spare_addr_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cfg = '0;
  logic [12:0] req_col = '0;
  logic [12:0] req_len = '0;
  logic        req_wr = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        req_ready, beat_valid, beat_wr, beat_spare, done, err, rd_valid;
  logic [12:0] beat_addr;
  logic [7:0]  rd_data;

  always #2 clk = ~clk;

  spare_addr_mapper u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cfg(req_cfg),
    .req_col(req_col), .req_len(req_len), .req_wr(req_wr), .wr_byte(wr_byte),
    .req_ready(req_ready), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_wr(beat_wr), .beat_spare(beat_spare), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]  cfg;
    logic [12:0] col;
    logic [12:0] len;
    logic [12:0] first;
    logic [12:0] last;
    logic [12:0] cnt;
    logic        err;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 13'd0,    13'd3,  13'd0,     13'd2,     13'd3,  1'b0, 4'd3},
    '{2'd0, 13'd500,  13'd20, 13'd500,   13'h1007,  13'd20, 1'b0, 4'd5},
    '{2'd3, 13'd4116, 13'd10, 13'h1014,  13'h1043,  13'd10, 1'b0, 4'd6},
    '{2'd3, 13'd4278, 13'd36, 13'h11C0,  13'h11E3,  13'd36, 1'b0, 4'd12},
    '{2'd1, 13'd2062, 13'd4,  13'h100E,  13'h1041,  13'd4,  1'b0, 4'd6},
    '{2'd2, 13'd4223, 13'd1,  13'h11CF,  13'h11CF,  13'd1,  1'b0, 4'd4},
    '{2'd1, 13'd2100, 13'd12, 13'h10C4,  13'h10CF,  13'd12, 1'b0, 4'd8},
    '{2'd1, 13'd2108, 13'd5,  13'd0,     13'd0,     13'd0,  1'b1, 4'd8},
    '{2'd2, 13'd100,  13'd0,  13'd0,     13'd0,     13'd0,  1'b0, 4'd9},
    '{2'd0, 13'd527,  13'd1,  13'h100F,  13'h100F,  13'd1,  1'b0, 4'd2},
    '{2'd2, 13'd4112, 13'd1,  13'h1040,  13'h1040,  13'd1,  1'b0, 4'd2},
    '{2'd3, 13'd4122, 13'd1,  13'h1040,  13'h1040,  13'd1,  1'b0, 4'd2},
    '{2'd3, 13'd4094, 13'd3,  13'd4094,  13'h1000,  13'd3,  1'b0, 4'd5}
  };

  int total = 0;
  int failed = 0;

  int          cap_cnt, cap_done_n, cap_rd_cnt;
  logic [12:0] cap_first, cap_last;
  logic        cap_err, cap_ready_low;
  logic [7:0]  cap_rd [64];

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] c, input logic [12:0] col,
                         input logic [12:0] len, input logic w, input bit inject);
    cap_cnt = 0; cap_done_n = 0; cap_rd_cnt = 0;
    cap_first = '0; cap_last = '0; cap_err = 1'b0; cap_ready_low = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_cfg = c; req_col = col; req_len = len; req_wr = w;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n < 200; n++) begin
      if (beat_valid) begin
        if (cap_cnt == 0) cap_first = beat_addr;
        cap_last = beat_addr;
        cap_cnt++;
      end
      if (rd_valid && cap_rd_cnt < 64) begin
        cap_rd[cap_rd_cnt] = rd_data;
        cap_rd_cnt++;
      end
      if (err) cap_err = 1'b1;
      if (done && cap_done_n == 0) cap_done_n = n;
      if (inject && n == 3) begin
        if (!req_ready) cap_ready_low = 1'b1;
        req_valid = 1'b1; req_col = 13'd0; req_len = 13'd3; req_wr = ~w;
      end
      if (inject && n == 4) req_valid = 1'b0;
      wr_byte = 8'hA0 + 8'(n - 1);
      if (cap_done_n != 0 && n >= cap_done_n + 2) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    failed++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "req_ready", 32'(req_ready), 32'd1);
    check("R1", "beat_valid/done/err/rd_valid",
          32'({beat_valid, done, err, rd_valid}), 32'd0);

    // table walk: R3 R4 R5 R6 R8 R9 R2 R12 addresses, R7 timing
    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i].cfg, VEC[i].col, VEC[i].len, 1'b0, 1'b0);
      check(tag_name(VEC[i].tag), $sformatf("vec %0d beat count", i),
            32'(cap_cnt), 32'(VEC[i].cnt));
      check(tag_name(VEC[i].tag), $sformatf("vec %0d err", i),
            32'(cap_err), 32'(VEC[i].err));
      if (VEC[i].cnt != 0) begin
        check(tag_name(VEC[i].tag), $sformatf("vec %0d first addr", i),
              32'(cap_first), 32'(VEC[i].first));
        check(tag_name(VEC[i].tag), $sformatf("vec %0d last addr", i),
              32'(cap_last), 32'(VEC[i].last));
      end
      check("R7", $sformatf("vec %0d done cycle", i), 32'(cap_done_n),
            32'((VEC[i].len == 0 || VEC[i].err) ? 2 : int'(VEC[i].len) + 1));
    end

    // R10: request pulsed while busy is ignored
    run_req(2'd2, 13'd4096, 13'd8, 1'b0, 1'b1);
    check("R10", "ready low while busy", 32'(cap_ready_low), 32'd1);
    check("R10", "beat count with stray request", 32'(cap_cnt), 32'd8);
    check("R10", "first addr with stray request", 32'(cap_first), 32'h1000);
    repeat (6) @(negedge clk);
    check("R10", "no beat after done", 32'(beat_valid), 32'd0);

    // R11: write spare bytes across a slot boundary, read them back
    run_req(2'd3, 13'd4116, 13'd10, 1'b1, 1'b0);
    check("R11", "write produces no rd_valid", 32'(cap_rd_cnt), 32'd0);
    run_req(2'd3, 13'd4116, 13'd10, 1'b0, 1'b0);
    check("R11", "read byte count", 32'(cap_rd_cnt), 32'd10);
    for (int k = 0; k < 10; k++)
      check("R11", $sformatf("read byte %0d", k), 32'(cap_rd[k]), 32'(8'hA0 + 8'(k)));
    run_req(2'd2, 13'd10, 13'd3, 1'b0, 1'b0);
    check("R11", "main read gives no rd_valid", 32'(cap_rd_cnt), 32'd0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule